// File: doc/BRIEF.md
# Serial Converter Command Shifter

This block turns byte accesses from a host register port into a three-wire serial control stream for two converter chips: an output (playback) converter and an input (capture) converter. Host reads frame the transfer. A read of one offset selects the output converter and a read of another selects the input converter. A read of a third offset ends the frame. While a frame is open, each byte the host writes to the data offset produces exactly one serial clock pulse. The bit carried by that pulse is bit 7 of the written byte.

Output-converter frames are 16 bits long and are sent most significant bit first. The upper byte holds a command and address, and the lower byte holds the value. A typical power-up sequence is 0xA007, then 0xA240, then 0xA30D, then 0xA103. Input-converter frames are 32 bits long, also most significant bit first, laid out as {mic level, mic level, right line level, left line level}. The block counts the bits of each frame. When the frame closes, a flag reports whether the count differed from the length the target expects.

Top module: `codec_cmd_shifter`

## Requirements
- R1: After reset both chip-selects are high, the serial clock is high, serial data is 0, busy is 0 and the length-error flag is 0.
- R2: A host read of offset 0x38 with no frame open drives the output-converter chip-select (`dac_cs_n`) low in the cycle after the read.
- R3: A host read of offset 0x2C with no frame open drives the input-converter chip-select (`adc_cs_n`) low in the cycle after the read.
- R4: A host read of offset 0x28 while a frame is open returns both chip-selects high in the cycle after the read.
- R5: A write to offset 0x2C during an open frame has three effects. Serial data takes bit 7 of the byte, and the other seven bits have no effect. The serial clock goes low for PHASE_CYC cycles and then high for PHASE_CYC cycles. Serial data stays stable for the whole pulse, and the bits come out in write order.
- R6: A write to offset 0x2C while no frame is open is ignored: the serial clock does not toggle and serial data keeps its value.
- R7: While `ser_busy` is high, every host read and write is ignored. This includes data writes, which emit no bit, and close reads, which leave the chip-select low.
- R8: When a frame closes, `frame_len_err` becomes 1 if the number of bits sent differs from the target's length (16 for the output converter, 32 for the input converter), and becomes 0 otherwise. Opening the next frame clears it.
- R9: The per-frame bit counter saturates at 63 and does not wrap. For example, 96 bits in an input frame still report a length error.
- R10: An open read while a frame is already open is ignored, and the open target keeps its chip-select.
- R11: A close read while no frame is open is ignored and leaves `frame_len_err` unchanged. Reads and writes at any other offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd | input | 1 | One-cycle host read strobe |
| host_wr | input | 1 | One-cycle host byte write strobe |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 8 | Host write byte; bit 7 is the serial bit |
| dac_cs_n | output | 1 | Output-converter chip-select, active low |
| adc_cs_n | output | 1 | Input-converter chip-select, active low |
| ser_clk | output | 1 | Serial clock, idle high, rising edge samples |
| ser_dat | output | 1 | Serial data |
| ser_busy | output | 1 | High while a serial pulse is in progress |
| frame_len_err | output | 1 | Bit count of the last closed frame was wrong |

## Verification
The hardest cases to reach are host accesses that land while a pulse is still running. The bench reaches them by issuing a second data write and then a close read on the cycles right after a data write, without waiting. The scoreboard then sees only one bit, and the chip-select stays low. Counter saturation needs a frame longer than 64 bits. The bench sends 96 bits to the input converter, because a counter that wrapped would read 32 and would wrongly report the frame as correct.

// File: rtl/cmdshift_pkg.sv
package cmdshift_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_DAC  = 2'd1,
    TGT_ADC  = 2'd2
  } tgt_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/cmdshift_decode.sv
module cmdshift_decode #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int BIT_POS   = 7,
  parameter logic [ADDR_W-1:0] A_DATA     = 8'h2C,
  parameter logic [ADDR_W-1:0] A_OPEN_DAC = 8'h38,
  parameter logic [ADDR_W-1:0] A_CLOSE    = 8'h28
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              req_open_dac,
  output logic              req_open_adc,
  output logic              req_close,
  output logic              req_bit,
  output logic              bit_val
);
  always_comb begin
    req_open_dac = rd && (addr == A_OPEN_DAC);
    req_open_adc = rd && (addr == A_DATA);
    req_close    = rd && (addr == A_CLOSE);
    req_bit      = wr && (addr == A_DATA);
    bit_val      = wdata[BIT_POS];
  end
endmodule

// File: rtl/cmdshift_frame.sv
module cmdshift_frame
  import cmdshift_pkg::*;
#(
  parameter int DAC_BITS = 16,
  parameter int ADC_BITS = 32,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_open_dac,
  input  logic             req_open_adc,
  input  logic             req_close,
  input  logic             req_bit,
  input  logic             busy,
  output tgt_e             tgt,
  output logic             bit_go,
  output logic             len_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] DAC_LEN = CNT_W'(DAC_BITS);
  localparam logic [CNT_W-1:0] ADC_LEN = CNT_W'(ADC_BITS);

  tgt_e             tgt_q, tgt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             open_now;
  logic [CNT_W-1:0] want_len;

  always_comb begin
    open_now = (tgt_q != TGT_NONE);
    want_len = (tgt_q == TGT_DAC) ? DAC_LEN : ADC_LEN;
    bit_go   = req_bit && open_now && !busy;
    tgt_d    = tgt_q;
    cnt_d    = cnt_q;
    err_d    = err_q;
    if (!busy) begin
      if (!open_now && req_open_dac) begin
        tgt_d = TGT_DAC;
        cnt_d = '0;
        err_d = 1'b0;
      end else if (!open_now && req_open_adc) begin
        tgt_d = TGT_ADC;
        cnt_d = '0;
        err_d = 1'b0;
      end else if (open_now && req_close) begin
        tgt_d = TGT_NONE;
        err_d = (cnt_q != want_len);
      end else if (bit_go && cnt_q != CNT_MAX) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= TGT_NONE;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      tgt_q <= tgt_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign tgt     = tgt_q;
  assign len_err = err_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_q != TGT_NONE && $past(tgt_q) == tgt_q) |->
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)) else $error("cnt step"); // R9
  AST_ERR_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($past(tgt_q) != TGT_NONE && tgt_q == TGT_NONE)) else $error("err rise"); // R8
endmodule

// File: rtl/cmdshift_pulse.sv
module cmdshift_pulse
  import cmdshift_pkg::*;
#(
  parameter int PHASE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bit_in,
  output logic sclk,
  output logic sdat,
  output logic busy
);
  localparam int PW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(PHASE_CYC - 1);

  phase_e        st_q, st_d;
  logic [PW-1:0] pc_q, pc_d;
  logic          dat_q, dat_d;

  always_comb begin
    st_d  = st_q;
    pc_d  = pc_q;
    dat_d = dat_q;
    unique case (st_q)
      PH_IDLE: if (start) begin
        st_d  = PH_LOW;
        pc_d  = '0;
        dat_d = bit_in;
      end
      PH_LOW: if (pc_q == PH_LAST) begin
        st_d = PH_HIGH;
        pc_d = '0;
      end else begin
        pc_d = pc_q + 1'b1;
      end
      PH_HIGH: if (pc_q == PH_LAST) begin
        st_d = PH_IDLE;
        pc_d = '0;
      end else begin
        pc_d = pc_q + 1'b1;
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      pc_q  <= '0;
      dat_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pc_q  <= pc_d;
      dat_q <= dat_d;
    end
  end

  assign sclk = (st_q != PH_LOW);
  assign sdat = dat_q;
  assign busy = (st_q != PH_IDLE);

  AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dat_q)) else $error("data moved"); // R5
  AST_RISE_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (busy && $past(st_q) == PH_LOW)) else $error("bad rise"); // R5
endmodule

// File: rtl/codec_cmd_shifter.sv
module codec_cmd_shifter
  import cmdshift_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int BIT_POS   = 7,
  parameter int PHASE_CYC = 2,
  parameter int DAC_BITS  = 16,
  parameter int ADC_BITS  = 32,
  parameter int CNT_W     = 6,
  parameter logic [ADDR_W-1:0] A_DATA     = 8'h2C,
  parameter logic [ADDR_W-1:0] A_OPEN_DAC = 8'h38,
  parameter logic [ADDR_W-1:0] A_CLOSE    = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              dac_cs_n,
  output logic              adc_cs_n,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              ser_busy,
  output logic              frame_len_err
);
  logic req_open_dac, req_open_adc, req_close, req_bit, bit_val, bit_go;
  tgt_e tgt;

  cmdshift_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_POS(BIT_POS),
    .A_DATA(A_DATA), .A_OPEN_DAC(A_OPEN_DAC), .A_CLOSE(A_CLOSE)
  ) u_dec (
    .rd(host_rd), .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
    .req_open_dac(req_open_dac), .req_open_adc(req_open_adc),
    .req_close(req_close), .req_bit(req_bit), .bit_val(bit_val)
  );

  cmdshift_frame #(
    .DAC_BITS(DAC_BITS), .ADC_BITS(ADC_BITS), .CNT_W(CNT_W)
  ) u_frame (
    .clk(clk), .rst_n(rst_n),
    .req_open_dac(req_open_dac), .req_open_adc(req_open_adc),
    .req_close(req_close), .req_bit(req_bit), .busy(ser_busy),
    .tgt(tgt), .bit_go(bit_go), .len_err(frame_len_err)
  );

  cmdshift_pulse #(.PHASE_CYC(PHASE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(bit_go), .bit_in(bit_val),
    .sclk(ser_clk), .sdat(ser_dat), .busy(ser_busy)
  );

  assign dac_cs_n = (tgt != TGT_DAC);
  assign adc_cs_n = (tgt != TGT_ADC);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~dac_cs_n, ~adc_cs_n})) else $error("two selects"); // R10
  AST_LOW_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_clk |-> (!dac_cs_n || !adc_cs_n)) else $error("clock outside frame"); // R6
  AST_IDLE_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_DATA && dac_cs_n && adc_cs_n && !ser_busy) |=> ser_clk)
    else $error("idle write toggled"); // R6
  AST_BUSY_HOLDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_busy && !dac_cs_n) |=> !dac_cs_n) else $error("cs dropped in pulse"); // R7
endmodule

// File: tb/codec_cmd_shifter_tb_top.sv
module codec_cmd_shifter_tb_top;
  localparam int P = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_addr = 8'h00, host_wdata = 8'h00;
  logic dac_cs_n, adc_cs_n, ser_clk, ser_dat, ser_busy, frame_len_err;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit exp_q[$];

  always #4 clk = ~clk;

  codec_cmd_shifter #(.PHASE_CYC(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .dac_cs_n(dac_cs_n), .adc_cs_n(adc_cs_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .ser_busy(ser_busy), .frame_len_err(frame_len_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every serial clock rise
  bit prev_sclk = 1'b1;
  int low_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ser_clk) low_len++;
      if (ser_clk && !prev_sclk) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected serial bit", 1, 0);
        end else begin
          automatic bit e = exp_q.pop_front();
          chk(ser_dat == e, "R5 serial bit", ser_dat, e);
        end
        chk(low_len == P, "R5 low phase length", low_len, P);
        low_len = 0;
      end
      prev_sclk = ser_clk;
    end
  end

  task automatic rd(input logic [7:0] a);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic wr_bit(input bit b, input bit expect_it);
    @(negedge clk); host_wr = 1'b1; host_addr = 8'h2C;
    host_wdata = {b, b ? 7'h2A : 7'h55};
    if (expect_it) exp_q.push_back(b);
    @(negedge clk); host_wr = 1'b0;
    repeat (2*P) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n-1; i >= 0; i--) wr_bit(v[i], 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dac_cs_n && adc_cs_n, "R1 cs idle", {dac_cs_n, adc_cs_n}, 3);
    chk(ser_clk == 1 && ser_dat == 0 && !ser_busy, "R1 serial idle", {ser_clk, ser_dat, ser_busy}, 4);
    chk(frame_len_err == 0, "R1 err clear", frame_len_err, 0);

    // R6 write with no frame open
    wr_bit(1'b1, 1'b0);
    chk(ser_clk && ser_dat == 0, "R6 idle write dropped", {ser_clk, ser_dat}, 2);
    // R11 close with no frame, other offsets
    rd(8'h28);
    chk(frame_len_err == 0 && dac_cs_n && adc_cs_n, "R11 stray close", frame_len_err, 0);
    rd(8'h30);
    chk(dac_cs_n && adc_cs_n, "R11 other offset read", {dac_cs_n, adc_cs_n}, 3);

    // R2 power-up sequence to output converter
    begin
      logic [15:0] seq [4] = '{16'hA007, 16'hA240, 16'hA30D, 16'hA103};
      foreach (seq[k]) begin
        rd(8'h38);
        chk(!dac_cs_n && adc_cs_n, "R2 open dac", {dac_cs_n, adc_cs_n}, 1);
        if (k == 0) begin
          rd(8'h2C); // R10 second open ignored
          chk(!dac_cs_n && adc_cs_n, "R10 reopen ignored", {dac_cs_n, adc_cs_n}, 1);
          @(negedge clk); host_wr = 1'b1; host_addr = 8'h40; host_wdata = 8'h80;
          @(negedge clk); host_wr = 1'b0;
          chk(ser_clk && !ser_busy, "R11 other offset write", ser_clk, 1);
        end
        send({16'h0, seq[k]}, 16);
        rd(8'h28);
        chk(dac_cs_n && adc_cs_n, "R4 close", {dac_cs_n, adc_cs_n}, 3);
        chk(frame_len_err == 0, "R8 dac 16 ok", frame_len_err, 0);
      end
    end

    // R3 input frame {mic, mic, right, left}
    rd(8'h2C);
    chk(adc_cs_n == 0 && dac_cs_n, "R3 open adc", {dac_cs_n, adc_cs_n}, 2);
    send({8'h5C, 8'h5C, 8'h91, 8'h0E}, 32);
    rd(8'h28);
    chk(frame_len_err == 0 && adc_cs_n, "R8 adc 32 ok", frame_len_err, 0);

    // R8 short dac frame
    rd(8'hB8 ^ 8'h80);
    send(32'h0000_3A6F, 15);
    rd(8'h28);
    chk(frame_len_err == 1, "R8 dac 15 bits", frame_len_err, 1);
    rd(8'h38);
    chk(frame_len_err == 0, "R8 open clears err", frame_len_err, 0);
    // R7 accesses while busy
    @(negedge clk); host_wr = 1'b1; host_addr = 8'h2C; host_wdata = 8'h80; exp_q.push_back(1'b1);
    @(negedge clk); host_wdata = 8'h00;
    chk(ser_busy == 1, "R7 busy after write", ser_busy, 1);
    @(negedge clk); host_wr = 1'b0; host_rd = 1'b1; host_addr = 8'h28;
    @(negedge clk); host_rd = 1'b0;
    repeat (2*P) @(negedge clk);
    chk(!dac_cs_n, "R7 close while busy ignored", dac_cs_n, 0);
    chk(exp_q.size() == 0 && ser_dat == 1, "R7 write while busy ignored", ser_dat, 1);
    send(32'h0000_7FFF, 15);
    rd(8'h28);
    chk(frame_len_err == 0, "R8 dac 16 after busy drops", frame_len_err, 0);

    // R8 adc frame with 16 bits
    rd(8'h2C);
    send(32'h0000_A600, 16);
    rd(8'h28);
    chk(frame_len_err == 1, "R8 adc 16 bits", frame_len_err, 1);
    // R11 stray close keeps the flag
    rd(8'h28);
    chk(frame_len_err == 1, "R11 stray close keeps err", frame_len_err, 1);

    // R9 saturation: 96 bits into adc frame
    rd(8'h2C);
    for (int j = 0; j < 3; j++) send(32'hC3A5_0F96 ^ j, 32);
    rd(8'h28);
    chk(frame_len_err == 1, "R9 saturate no wrap", frame_len_err, 1);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all bits seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule